// File: doc/BRIEF.md
# TDM Frame Serial-to-Parallel Receiver

This block takes a time-division multiplexed serial stream, one bit per clock, and turns it back into channel bytes. A frame holds 256 bits, split into 32 time slots of 8 bits each. At a 2.048 MHz bit clock that gives 8000 frames per second. Alongside the data comes a frame marker that is one bit wide and lines up with the first bit of every frame. The receiver gathers bits in a shift register clocked by the bit clock. When a slot completes, it presents the byte together with the slot's index and a one-cycle strobe.

The bit and slot position does not simply run on from reset. Every frame marker forces it back to the first bit of slot 0. Byte boundaries therefore come from the marker, and a slip in the stream is repaired at the next frame start. Between markers the position keeps counting on its own and wraps from the last slot back to slot 0. Until the first marker after reset the receiver reports itself unlocked and produces no strobes. The asynchronous active-low reset is released inside the block through a two-stage synchronizer.

Top module: `tdm_deframer`

## Requirements
- R1: While reset is held, `chan_valid` and `locked` are 0, and `chan_byte` and `chan_slot` are all zeros.
- R2: Until a `frame_mark` has been sampled after reset, `locked` stays 0 and `chan_valid` never rises, whatever `ser_in` carries.
- R3: A `frame_mark` high at a sampling edge makes `locked` 1 from the next cycle on, and it stays 1 until reset.
- R4: Bits arrive most significant first: the first bit of a slot ends up in `chan_byte[7]` and the eighth bit in `chan_byte[0]`.
- R5: The cycle after the edge that samples the eighth bit of a slot, `chan_valid` is 1 for exactly one cycle, with the assembled byte on `chan_byte`.
- R6: `chan_slot` numbers slots 0 to 31 in arrival order. Without a new marker, slot 31 is followed by slot 0.
- R7: A `frame_mark` anywhere other than the first bit of slot 0 realigns the position. The bit sampled with it becomes bit 0 of slot 0, and any partly gathered bits are dropped without a strobe.
- R8: A `frame_mark` that coincides with the eighth bit of a slot takes priority. That slot gives no strobe, and the bit starts slot 0.
- R9: Between strobes, `chan_byte` and `chan_slot` hold the values of the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one data bit is sampled per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | 1 | Serial data bit |
| frame_mark | input | 1 | High for the first bit of a frame |
| chan_byte | output | 8 | Assembled channel byte (SLOT_BITS wide) |
| chan_slot | output | 5 | Slot index of `chan_byte` (log2 of NUM_SLOTS wide) |
| chan_valid | output | 1 | One-cycle strobe for a completed slot |
| locked | output | 1 | High once a frame marker has been seen since reset |

## Verification
The bench builds the receiver with its default shape of 8-bit slots and 32 slots per frame. A whole frame then takes only 256 cycles, so the wrap from slot 31 to slot 0 without a marker can be reached many times over in a short run. The marker is placed at frame start, in the middle of a slot, at the first bit of slot 5, on the eighth bit of a slot, and on two bits in a row. This exercises realignment, the dropping of partial bytes and the priority of the marker. All-zero and all-one bytes are mixed with irregular patterns to expose bit order and position errors.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned TDM_SLOT_BITS = 8;
  localparam int unsigned TDM_NUM_SLOTS = 32;

  // Per-bit action decided by the position counter, consumed by the assembler
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,  // not locked, bit ignored
    ACT_ALIGN = 2'd1,  // frame marker: bit is bit 0 of slot 0
    ACT_SHIFT = 2'd2,  // ordinary bit inside a slot
    ACT_CLOSE = 2'd3   // last bit of a slot: emit the byte
  } pos_act_t;
endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
  import tdm_rx_pkg::*;
#(
  parameter  int unsigned SLOT_BITS = TDM_SLOT_BITS,
  parameter  int unsigned NUM_SLOTS = TDM_NUM_SLOTS,
  localparam int unsigned BIT_W     = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1,
  localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_mark,
  output pos_act_t          act,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              framed
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              framed_q, framed_d;
  logic              pos_en;

  // Decide what the bit sampled this cycle means; the marker wins over all
  always_comb begin
    if (frame_mark)          act = ACT_ALIGN;
    else if (!framed_q)      act = ACT_IDLE;
    else if (bit_q == BIT_LAST) act = ACT_CLOSE;
    else                     act = ACT_SHIFT;
  end

  always_comb begin
    bit_d    = bit_q;
    slot_d   = slot_q;
    framed_d = framed_q;
    pos_en   = 1'b1;
    unique case (act)
      ACT_ALIGN: begin
        bit_d    = BIT_W'(1);
        slot_d   = '0;
        framed_d = 1'b1;
      end
      ACT_SHIFT: bit_d = bit_q + BIT_W'(1);
      ACT_CLOSE: begin
        bit_d  = '0;
        slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + SLOT_W'(1);
      end
      default:   pos_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '0;
      slot_q   <= '0;
      framed_q <= 1'b0;
    end else if (pos_en) begin
      bit_q    <= bit_d;
      slot_q   <= slot_d;
      framed_q <= framed_d;
    end
  end

  assign slot_idx = slot_q;
  assign framed   = framed_q;
endmodule

// File: rtl/tdm_byte_assembler.sv
module tdm_byte_assembler
  import tdm_rx_pkg::*;
#(
  parameter  int unsigned SLOT_BITS = TDM_SLOT_BITS,
  parameter  int unsigned NUM_SLOTS = TDM_NUM_SLOTS,
  localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned PART_W    = SLOT_BITS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pos_act_t             act,
  input  logic                 ser_in,
  input  logic [SLOT_W-1:0]    slot_idx,
  output logic [SLOT_BITS-1:0] out_byte,
  output logic [SLOT_W-1:0]    out_slot,
  output logic                 out_valid
);
  // Only the first SLOT_BITS-1 bits are stored; the last one joins on the fly
  logic [PART_W-1:0]    part_q, part_d;
  logic                 part_en;
  logic [SLOT_BITS-1:0] whole;
  logic [SLOT_BITS-1:0] byte_q;
  logic [SLOT_W-1:0]    slot_q;
  logic                 valid_q, valid_d;
  logic                 load_en;

  assign whole = {part_q, ser_in};

  always_comb begin
    part_d  = part_q;
    part_en = 1'b1;
    unique case (act)
      ACT_ALIGN: part_d = PART_W'(ser_in);   // drop whatever was gathered
      ACT_SHIFT: part_d = PART_W'(whole);
      ACT_CLOSE: part_d = '0;
      default:   part_en = 1'b0;
    endcase
    valid_d = (act == ACT_CLOSE);
    load_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q  <= '0;
      byte_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (part_en) part_q <= part_d;
      if (load_en) begin
        byte_q <= whole;
        slot_q <= slot_idx;
      end
    end
  end

  assign out_byte  = byte_q;
  assign out_slot  = slot_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/tdm_deframer.sv
module tdm_deframer
  import tdm_rx_pkg::*;
#(
  parameter  int unsigned SLOT_BITS = TDM_SLOT_BITS,
  parameter  int unsigned NUM_SLOTS = TDM_NUM_SLOTS,
  localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic                 frame_mark,
  output logic [SLOT_BITS-1:0] chan_byte,
  output logic [SLOT_W-1:0]    chan_slot,
  output logic                 chan_valid,
  output logic                 locked
);
  logic              rst_core_n;
  pos_act_t          act;
  logic [SLOT_W-1:0] slot_idx;

  tdm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tdm_slot_counter #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)) u_slot_counter (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .frame_mark (frame_mark),
    .act        (act),
    .slot_idx   (slot_idx),
    .framed     (locked)
  );

  tdm_byte_assembler #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)) u_byte_assembler (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .act       (act),
    .ser_in    (ser_in),
    .slot_idx  (slot_idx),
    .out_byte  (chan_byte),
    .out_slot  (chan_slot),
    .out_valid (chan_valid)
  );
endmodule

// File: rtl/tdm_deframer_chk.sv
module tdm_deframer_chk #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned SLOT_W    = 5
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic                 frame_mark,
  input logic [SLOT_BITS-1:0] chan_byte,
  input logic [SLOT_W-1:0]    chan_slot,
  input logic                 chan_valid,
  input logic                 locked
);
  // R2
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    chan_valid |-> locked);

  // R3
  lock_after_mark_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_mark |=> locked);

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    locked |=> locked);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    chan_valid |=> !chan_valid);

  // R8
  mark_blocks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_mark |=> !chan_valid);

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chan_valid |-> ($stable(chan_byte) && $stable(chan_slot)));
endmodule

bind tdm_deframer tdm_deframer_chk #(.SLOT_BITS(SLOT_BITS), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .frame_mark (frame_mark),
  .chan_byte  (chan_byte),
  .chan_slot  (chan_slot),
  .chan_valid (chan_valid),
  .locked     (locked)
);

// File: tb/tdm_deframer_bench.sv
module tdm_deframer_bench;
  localparam int SB = 8;
  localparam int NS = 32;
  localparam int SW = $clog2(NS);

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 20-unit period, 50 MHz

  logic          rst_n, ser_in, frame_mark;
  logic [SB-1:0] chan_byte;
  logic [SW-1:0] chan_slot;
  logic          chan_valid, locked;

  tdm_deframer #(.SLOT_BITS(SB), .NUM_SLOTS(NS)) u_tdm_deframer (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_mark(frame_mark),
    .chan_byte(chan_byte), .chan_slot(chan_slot), .chan_valid(chan_valid), .locked(locked)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string phase = "R5";
  logic [SW+SB-1:0] exp_q[$];

  // Bench-side position model built from the requirements
  bit            m_framed = 1'b0;
  int            m_pos    = 0;
  int            m_slot   = 0;
  logic [SB-1:0] m_acc    = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic drive_bit(input logic b, input logic s);
    @(posedge clk);
    #1;
    ser_in     = b;
    frame_mark = s;
    if (s) begin
      m_framed = 1'b1;
      m_acc    = SB'(b);
      m_pos    = 1;
      m_slot   = 0;
    end else if (m_framed) begin
      m_acc = {m_acc[SB-2:0], b};
      if (m_pos == SB - 1) begin
        exp_q.push_back({SW'(m_slot), m_acc});
        m_pos  = 0;
        m_slot = (m_slot + 1) % NS;
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic send_bits(input int n, input logic [SB-1:0] v, input bit mark_first);
    for (int i = 0; i < n; i++) drive_bit(v[SB-1-i], mark_first && (i == 0));
  endtask

  function automatic logic [SB-1:0] pat(input int seed, input int s);
    if (seed == 0) return (s % 2 == 1) ? '1 : '0;
    return SB'(seed * 29 + s * 53 + s * s) ^ SB'(seed * 7);
  endfunction

  task automatic send_slots(input int n, input bit mark_first, input int seed);
    for (int s = 0; s < n; s++) send_bits(SB, pat(seed, s), mark_first && (s == 0));
  endtask

  // Monitor: pops expected strobes and checks holding between them
  logic [SB-1:0]    last_byte;
  logic [SW-1:0]    last_slot;
  bit               has_last = 1'b0;
  logic [SW+SB-1:0] exp_item;

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        has_last = 1'b0;
      end else if (chan_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, phase, "unexpected strobe byte", int'(chan_byte), 0);
        end else begin
          exp_item = exp_q.pop_front();
          check(chan_slot == exp_item[SW+SB-1:SB], "R6", "slot index",
                int'(chan_slot), int'(exp_item[SW+SB-1:SB]));
          check(chan_byte == exp_item[SB-1:0], "R4/R5", "assembled byte",
                int'(chan_byte), int'(exp_item[SB-1:0]));
        end
        last_byte = chan_byte;
        last_slot = chan_slot;
        has_last  = 1'b1;
      end else if (has_last) begin
        check(chan_byte == last_byte && chan_slot == last_slot, "R9", "held byte",
              int'(chan_byte), int'(last_byte));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R5 watchdog: got timeout expected finish");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b1;
    ser_in     = 1'b0;
    frame_mark = 1'b0;
    #2 rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(chan_valid == 1'b0, "R1", "chan_valid in reset", int'(chan_valid), 0);
    check(locked == 1'b0,     "R1", "locked in reset",     int'(locked), 0);
    check(chan_byte == '0,    "R1", "chan_byte in reset",  int'(chan_byte), 0);
    check(chan_slot == '0,    "R1", "chan_slot in reset",  int'(chan_slot), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: traffic without any marker
    phase = "R2";
    for (int i = 0; i < 40; i++) drive_bit(logic'((i % 3) == 0), 1'b0);
    @(negedge clk);
    check(locked == 1'b0, "R2", "locked before marker", int'(locked), 0);

    // R3/R5: first marked frame
    phase = "R5";
    send_slots(NS, 1'b1, 1);
    @(negedge clk);
    check(locked == 1'b1, "R3", "locked after marker", int'(locked), 1);

    // R6: free-running frame, no marker, slot wraps
    phase = "R6";
    send_slots(NS, 1'b0, 2);
    // R4: all-zero and all-one bytes
    phase = "R4";
    send_slots(NS, 1'b1, 0);

    // R7: marker in the middle of a slot
    phase = "R7";
    send_slots(3, 1'b1, 3);
    send_bits(5, 8'hC3, 1'b0);
    send_slots(NS, 1'b1, 4);

    // R7: marker at bit 0 of slot 5
    send_slots(5, 1'b0, 5);
    send_slots(NS, 1'b1, 6);

    // R8: marker on the eighth bit of a slot
    phase = "R8";
    send_slots(2, 1'b0, 7);
    send_bits(7, 8'h5A, 1'b0);
    send_slots(NS, 1'b1, 8);

    // R7: markers on two bits in a row
    phase = "R7";
    drive_bit(1'b1, 1'b1);
    drive_bit(1'b0, 1'b1);
    send_slots(NS, 1'b1, 9);

    repeat (3) @(negedge clk);
    check(locked == 1'b1, "R3", "locked stays set", int'(locked), 1);
    check(exp_q.size() == 0, "R5", "strobes still pending", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule